// File: doc/BRIEF.md
# Set/Clear DMA Control Register

This block holds the enable bits for a family of DMA channels and updates them through a set/clear write protocol. Each write carries an operation bit in position 15. If that bit is 1, every lower bit written as 1 is turned on. If it is 0, every lower bit written as 1 is turned off. Bits written as 0 are never touched. Software can therefore change any group of enables without first reading the register back.

A separate read port returns the stored control bits together with two live status flags from the blitter: busy and zero-result. The block drives nine registered effective enables, one each for bitplane, copper, blitter, sprite, disk and audio channels 3 to 0. Each of these is gated by a master enable. The block also produces a processor hold-off signal. It is raised while the blitter has bus priority, its DMA is enabled, and it reports busy.

Top module: `dma_ctl_reg`

## Requirements
- R1: While reset is low, and after it is released with no write, the stored control bits (10:0) are 0, `chanEn` is 0 and `cpuYield` is 0.
- R2: On a clock edge with `wrEn` high and `wrData[15]` = 1, every stored bit in 10:0 whose `wrData` bit is 1 becomes 1.
- R3: On a clock edge with `wrEn` high and `wrData[15]` = 0, every stored bit in 10:0 whose `wrData` bit is 1 becomes 0.
- R4: Stored bits whose `wrData` bit is 0 keep their value during a write.
- R5: `rdData[14]` follows `blitBusy` and `rdData[13]` follows `blitZero` in the same cycle, with no register in between. Writing 1 to bits 14 or 13 changes no stored bit.
- R6: `rdData[15]`, `rdData[12]` and `rdData[11]` always read 0. Writing bits 12 and 11 changes no stored bit.
- R7: `chanEn[i]` for i in 8..0 equals stored bit i ANDed with the master enable (stored bit 9), registered, so it appears one clock after the stored bits. The channel order from 8 down to 0 is bitplane, copper, blitter (bit 6), sprite, disk, audio 3, 2, 1, 0.
- R8: `cpuYield` is 1 exactly when stored bit 10 (priority), `chanEn[6]` and `blitBusy` are all 1. It responds to `blitBusy` in the same cycle.
- R9: With `wrEn` low, the stored bits do not change, whatever is on `wrData`.
- R10: `rdData[10:0]` shows the stored control bits in the same cycle that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write strobe for one cycle |
| wrData | input | 16 | Write value; bit 15 selects set (1) or clear (0) |
| blitBusy | input | 1 | Blitter busy status |
| blitZero | input | 1 | Blitter zero-result status |
| rdData | output | 16 | Read value: status in 14:13, control in 10:0 |
| chanEn | output | 9 | Effective channel enables, registered |
| cpuYield | output | 1 | Holds the processor off the bus |

## Verification
Two events can land in the same cycle: a write that changes the control bits, and a change of the live blitter status. The stimulus table therefore changes `blitBusy` and `blitZero` in the same cycle as each write. The bench then checks that the read value shows the new stored bits next to the new status flags. A second overlap arises when one write sets the master enable and channel bits together, or clears the master while channel bits stay set. In those cases the registered enables and the hold-off output are checked one clock later than the read value.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int DATA_W     = 16;
  localparam int STORE_W    = 11;
  localparam int NUM_CHAN   = 9;
  localparam int BIT_OP     = 15;
  localparam int BIT_BUSY   = 14;
  localparam int BIT_ZERO   = 13;
  localparam int BIT_PRI    = 10;
  localparam int BIT_MASTER = 9;
  localparam int BIT_BLIT   = 6;

  typedef struct packed {
    logic               setStb;
    logic               clrStb;
    logic [STORE_W-1:0] mask;
  } ctlStrobe_t;
endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
(
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output ctlStrobe_t        strobe
);
  // bits between the status field and the stored field carry no meaning on write
  logic unusedHi;
  assign unusedHi = ^wrData[BIT_OP-1:STORE_W];

  always_comb begin
    strobe.setStb = wrEn & wrData[BIT_OP];
    strobe.clrStb = wrEn & ~wrData[BIT_OP];
    strobe.mask   = wrData[STORE_W-1:0];
  end
endmodule

// File: rtl/dma_ctl_store.sv
module dma_ctl_store
  import dma_ctl_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic                blitBusy,
  input  logic                blitZero,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_CHAN-1:0] chanEn,
  output logic                cpuYield
);
  localparam int PAD_W = BIT_ZERO - STORE_W;

  logic [STORE_W-1:0]  ctrlQ;
  logic [NUM_CHAN-1:0] chanEnQ;

  for (genvar b = 0; b < STORE_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN)
        ctrlQ[b] <= 1'b0;
      else if (strobe.mask[b] && strobe.setStb)
        ctrlQ[b] <= 1'b1;
      else if (strobe.mask[b] && strobe.clrStb)
        ctrlQ[b] <= 1'b0;
    end
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) chanEnQ[c] <= 1'b0;
      else       chanEnQ[c] <= ctrlQ[c] & ctrlQ[BIT_MASTER];
    end
  end

  assign rdData   = {1'b0, blitBusy, blitZero, {PAD_W{1'b0}}, ctrlQ};
  assign chanEn   = chanEnQ;
  assign cpuYield = ctrlQ[BIT_PRI] & chanEnQ[BIT_BLIT] & blitBusy;
endmodule

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
  import dma_ctl_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                blitBusy,
  input  logic                blitZero,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_CHAN-1:0] chanEn,
  output logic                cpuYield
);
  ctlStrobe_t strobe;

  dma_ctl_decode u_decode (
    .wrEn   (wrEn),
    .wrData (wrData),
    .strobe (strobe)
  );

  dma_ctl_store u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .blitBusy (blitBusy),
    .blitZero (blitZero),
    .rdData   (rdData),
    .chanEn   (chanEn),
    .cpuYield (cpuYield)
  );
endmodule

// File: rtl/dma_ctl_reg_chk.sv
module dma_ctl_reg_chk
  import dma_ctl_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [DATA_W-1:0]   wrData,
  input logic                blitBusy,
  input logic                blitZero,
  input logic [DATA_W-1:0]   rdData,
  input logic [NUM_CHAN-1:0] chanEn,
  input logic                cpuYield
);
  p_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[BIT_OP]) |=>
      ((rdData[STORE_W-1:0] & $past(wrData[STORE_W-1:0])) == $past(wrData[STORE_W-1:0])));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[BIT_OP]) |=>
      ((rdData[STORE_W-1:0] & $past(wrData[STORE_W-1:0])) == '0));

  p_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=>
      ((rdData[STORE_W-1:0] & ~$past(wrData[STORE_W-1:0])) ==
       ($past(rdData[STORE_W-1:0]) & ~$past(wrData[STORE_W-1:0]))));

  p_status_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[BIT_BUSY] == blitBusy) && (rdData[BIT_ZERO] == blitZero));

  p_spare_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[BIT_OP] == 1'b0) && (rdData[BIT_ZERO-1:STORE_W] == '0));

  p_chan_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (chanEn == ($past(rdData[BIT_MASTER]) ? $past(rdData[NUM_CHAN-1:0]) : '0)));

  p_yield_r8: assert property (@(posedge clk) disable iff (!rstN)
    cpuYield |-> (blitBusy && rdData[BIT_PRI] && chanEn[BIT_BLIT]));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData[STORE_W-1:0]));
endmodule

bind dma_ctl_reg dma_ctl_reg_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .blitBusy (blitBusy),
  .blitZero (blitZero),
  .rdData   (rdData),
  .chanEn   (chanEn),
  .cpuYield (cpuYield)
);

// File: tb/dma_ctl_reg_tb_top.sv
module dma_ctl_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {wrData, busy, zero, expRd, expChan, expYield}
  localparam logic [43:0] VEC [NVEC] = '{
    {16'h8640, 1'b1, 1'b0, 16'h4640, 9'h040, 1'b1},
    {16'h8001, 1'b0, 1'b1, 16'h2641, 9'h041, 1'b0},
    {16'h0200, 1'b1, 1'b1, 16'h6441, 9'h000, 1'b0},
    {16'hF800, 1'b0, 1'b0, 16'h0441, 9'h000, 1'b0},
    {16'h81FF, 1'b1, 1'b0, 16'h45FF, 9'h000, 1'b0},
    {16'h8200, 1'b1, 1'b0, 16'h47FF, 9'h1FF, 1'b1},
    {16'h0040, 1'b1, 1'b0, 16'h47BF, 9'h1BF, 1'b0},
    {16'h7FFF, 1'b0, 1'b1, 16'h2000, 9'h000, 1'b0},
    {16'h8000, 1'b0, 1'b0, 16'h0000, 9'h000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        blitBusy = 1'b0;
  logic        blitZero = 1'b0;
  logic [15:0] rdData;
  logic [8:0]  chanEn;
  logic        cpuYield;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_ctl_reg dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .blitBusy(blitBusy), .blitZero(blitZero),
    .rdData(rdData), .chanEn(chanEn), .cpuYield(cpuYield)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = 16'h0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 rd in reset", rdData, 16'h0000);
    chk("R1 chan in reset", {7'd0, chanEn}, 16'h0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1 rd after reset", rdData, 16'h0000);
    chk("R1 yield after reset", {15'd0, cpuYield}, 16'h0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wrEn = 1'b1; wrData = VEC[i][43:28];
      blitBusy = VEC[i][27]; blitZero = VEC[i][26];
      @(negedge clk);
      wrEn = 1'b0; wrData = 16'h0;
      chk("R2/R3/R4/R5/R6/R10 read", rdData, VEC[i][25:10]);
      @(negedge clk);
      chk("R7 chanEn", {7'd0, chanEn}, {7'd0, VEC[i][9:1]});
      chk("R8 cpuYield", {15'd0, cpuYield}, {15'd0, VEC[i][0]});
    end

    // R9: idle write strobe, data ignored
    @(negedge clk); wrEn = 1'b0; wrData = 16'h87FF;
    @(negedge clk); @(negedge clk);
    chk("R9 idle data ignored", rdData, 16'h0000);
    chk("R9 idle chan", {7'd0, chanEn}, 16'h0);
    wrData = 16'h0;

    // R5: status follows live without a clock edge
    #1 blitBusy = 1'b1; blitZero = 1'b1; #1;
    chk("R5 live status", rdData, 16'h6000);
    #1 blitBusy = 1'b0; blitZero = 1'b0; #1;
    chk("R5 live status low", rdData, 16'h0000);

    // R7: one-cycle latency of effective enables
    @(negedge clk); wrEn = 1'b1; wrData = 16'h8650;
    @(negedge clk); wrEn = 1'b0; wrData = 16'h0;
    chk("R10 stored visible", rdData, 16'h0650);
    chk("R7 not yet enabled", {7'd0, chanEn}, 16'h0);
    @(negedge clk);
    chk("R7 enabled after one clock", {7'd0, chanEn}, 16'h0050);

    // R8: hold-off tracks busy in the same cycle
    #1 blitBusy = 1'b1; #1;
    chk("R8 yield on busy", {15'd0, cpuYield}, 16'h1);
    #1 blitBusy = 1'b0; #1;
    chk("R8 yield off", {15'd0, cpuYield}, 16'h0);

    // R2/R4: set one bit while others stay
    doWrite(16'h8008);
    chk("R4 others kept on set", rdData, 16'h0658);
    // R3/R4: clear one bit
    doWrite(16'h0010);
    chk("R3 clear one bit", rdData, 16'h0648);
    // R6: spare bits on write do not stick
    doWrite(16'h9800);
    chk("R6 spare bits ignored", rdData, 16'h0648);

    // R1: reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run rd", rdData, 16'h0000);
    chk("R1 reset mid-run chan", {7'd0, chanEn}, 16'h0);
    rstN = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule